// File: doc/BRIEF.md
# Variable-Format Microprogram Sequencer

This block is the address-sequencing core of a microprogrammed control unit. It holds a small constant control store and steps through it one microinstruction per clock. Each stored word is one of two formats, chosen by its top bit. A control-format word drives the control outputs. Its successor is either the next address or an entry point taken from the current opcode. A branch-format word drives no control at all. It tests one of the flags, optionally inverted, and either jumps to its target or falls through to the next address. Each branch therefore costs one microcycle in which the datapath does nothing.

After reset the sequencer is idle at address 0 with every output inactive. A single `start` pulse sets it running, and it keeps running until the next reset. The opcode and flags are plain level inputs, sampled at the clock edge that ends a dispatching control word or a branch word. The block has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `usq_sequencer`

## Requirements
- R1: While reset is asserted, and afterwards until `start_i` is sampled high, `upc_o` is 0, `ctrl_o` is 0 and `br_cycle_o` is 0.
- R2: `start_i` sampled high while idle starts execution at address 0 in the next cycle. `start_i` has no effect while running, and the sequence continues unchanged.
- R3: Bit 9 of a stored word selects its format: 0 for control, 1 for branch. While a control word is current, `ctrl_o` equals its bits [7:0] and `br_cycle_o` is 0.
- R4: A control word with bit 8 clear is followed by address `upc_o`+1, modulo 32.
- R5: A control word with bit 8 set is followed by address 16 + 4*`opcode_i`, using the opcode sampled at that edge.
- R6: While a branch word is current, `br_cycle_o` is 1 and `ctrl_o` is all zero for that single cycle.
- R7: A branch word's bits [6:5] choose its condition source: 0 is constant true, and s = 1..3 is `flags_i[s-1]`. Bit 7 inverts the condition. When the result is true, the next address is bits [4:0].
- R8: A branch whose condition result is false falls through to `upc_o`+1, modulo 32.
- R9: The store holds the following words. At addresses 0..3 are control words with `ctrl` = address+1; only address 3 has the dispatch bit set. Addresses 4..15 hold unconditional branches to 0. The routine for opcode k starts at B = 16+4k and has four words. B is a branch with source k, no inversion, and target B+2. B+1 is a sequential control word with `ctrl` = 0x20|k. B+2 is a sequential control word with `ctrl` = 0x40|k. B+3 is a branch with source k, inverted, and target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin execution when idle |
| opcode_i | input | 2 | Opcode used by dispatching control words |
| flags_i | input | 3 | Status flags tested by branch words |
| ctrl_o | output | 8 | Control signals of the current control word |
| br_cycle_o | output | 1 | High during a branch-format cycle |
| upc_o | output | 5 | Current control-store address |

## Verification
The hardest cases to reach are the not-taken paths of the inverted branches. Only specific pairings of opcode and flag value exercise them. One of them is the opcode-0 exit branch, which can never be taken, so control falls through into the next routine. Another is the opcode-3 exit, where fall-through wraps the address from 31 back to 0. The stimulus sweeps every opcode against every flag value, runs long enough to pass through two routines, and pulses `start_i` in the middle of each run. A reference walk of the stored program predicts every cycle.

// File: rtl/usq_pkg.sv
package usq_pkg;
  typedef enum logic {FMT_CTRL = 1'b0, FMT_BRANCH = 1'b1} ufmt_e;
  localparam int unsigned COND_SEL_W = 2;
endpackage

// File: rtl/usq_store.sv
module usq_store #(
  parameter int unsigned AW  = 5,
  parameter int unsigned CW  = 8,
  parameter int unsigned OPW = 2,
  parameter int unsigned SW  = 2,
  parameter int unsigned WW  = 10
) (
  input  logic [AW-1:0] addr_i,
  output logic [WW-1:0] word_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned BASE  = 1 << (AW - 1);
  localparam int unsigned SLOT  = 1 << (AW - 1 - OPW);

  function automatic logic [WW-1:0] mk_ctrl(input logic disp, input int unsigned c);
    logic [WW-1:0] w;
    w = '0;
    w[WW-1]   = usq_pkg::FMT_CTRL;
    w[CW]     = disp;
    w[CW-1:0] = CW'(c);
    return w;
  endfunction

  function automatic logic [WW-1:0] mk_br(input int unsigned sel, input logic inv,
                                          input int unsigned tgt);
    logic [WW-1:0] w;
    w = '0;
    w[WW-1]         = usq_pkg::FMT_BRANCH;
    w[AW+SW]        = inv;
    w[AW+SW-1:AW]   = SW'(sel);
    w[AW-1:0]       = AW'(tgt);
    return w;
  endfunction

  function automatic logic [WW-1:0] word_at(input int unsigned a);
    int unsigned k;
    int unsigned j;
    if (a < 4) return mk_ctrl(a == 3, a + 1);
    if (a < BASE) return mk_br(0, 1'b0, 0);
    k = (a - BASE) / SLOT;
    j = (a - BASE) % SLOT;
    case (j)
      0:       return mk_br(k, 1'b0, a + 2);
      1:       return mk_ctrl(1'b0, 32'h20 | k);
      2:       return mk_ctrl(1'b0, 32'h40 | k);
      default: return mk_br(k, 1'b1, 0);
    endcase
  endfunction

  logic [WW-1:0] rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    assign rom[gi] = word_at(gi);
  end

  assign word_o = rom[addr_i];
endmodule

// File: rtl/usq_cond.sv
module usq_cond #(
  parameter int unsigned SW = 2
) (
  input  logic [(1<<SW)-2:0] flags_i,
  input  logic [SW-1:0]      sel_i,
  input  logic               inv_i,
  output logic               taken_o
);
  localparam int unsigned NSRC = 1 << SW;
  logic [NSRC-1:0] srcs;

  assign srcs    = {flags_i, 1'b1};
  assign taken_o = srcs[sel_i] ^ inv_i;
endmodule

// File: rtl/usq_next.sv
module usq_next #(
  parameter int unsigned AW  = 5,
  parameter int unsigned OPW = 2
) (
  input  logic           run_i,
  input  logic           start_i,
  input  logic           is_br_i,
  input  logic           disp_i,
  input  logic           taken_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  tgt_i,
  input  logic [OPW-1:0] opcode_i,
  output logic [AW-1:0]  pc_d,
  output logic           run_d
);
  localparam int unsigned SHIFT = AW - 1 - OPW;
  logic [AW-1:0] entry;
  logic [AW-1:0] seq;

  assign entry = AW'(1 << (AW - 1)) | (AW'(opcode_i) << SHIFT);
  assign seq   = pc_i + 1'b1;
  assign run_d = run_i | start_i;

  always_comb begin
    if (!run_i)       pc_d = '0;
    else if (is_br_i) pc_d = taken_i ? tgt_i : seq;
    else if (disp_i)  pc_d = entry;
    else              pc_d = seq;
  end
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer #(
  parameter int unsigned AW  = 5,
  parameter int unsigned CW  = 8,
  parameter int unsigned OPW = 2,
  parameter int unsigned SW  = usq_pkg::COND_SEL_W,
  localparam int unsigned FW = (1 << SW) - 1,
  localparam int unsigned WW = 1 + (((CW + 1) > (AW + SW + 1)) ? (CW + 1) : (AW + SW + 1))
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [OPW-1:0] opcode_i,
  input  logic [FW-1:0]  flags_i,
  output logic [CW-1:0]  ctrl_o,
  output logic           br_cycle_o,
  output logic [AW-1:0]  upc_o
);
  import usq_pkg::*;

  logic          run_q;
  logic [AW-1:0] pc_q;
  logic [WW-1:0] cur_word;
  ufmt_e         fmt;
  logic          disp_bit;
  logic [AW-1:0] br_tgt;
  logic          taken;
  logic [AW-1:0] pc_d;
  logic          run_d;

  usq_store #(.AW(AW), .CW(CW), .OPW(OPW), .SW(SW), .WW(WW)) u_store (
    .addr_i (pc_q),
    .word_o (cur_word)
  );

  assign fmt      = ufmt_e'(cur_word[WW-1]);
  assign disp_bit = cur_word[CW];
  assign br_tgt   = cur_word[AW-1:0];

  usq_cond #(.SW(SW)) u_cond (
    .flags_i (flags_i),
    .sel_i   (cur_word[AW+SW-1:AW]),
    .inv_i   (cur_word[AW+SW]),
    .taken_o (taken)
  );

  usq_next #(.AW(AW), .OPW(OPW)) u_next (
    .run_i    (run_q),
    .start_i  (start_i),
    .is_br_i  (fmt == FMT_BRANCH),
    .disp_i   (disp_bit),
    .taken_i  (taken),
    .pc_i     (pc_q),
    .tgt_i    (br_tgt),
    .opcode_i (opcode_i),
    .pc_d     (pc_d),
    .run_d    (run_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      run_q <= run_d;
      pc_q  <= pc_d;
    end
  end

  assign upc_o      = pc_q;
  assign br_cycle_o = run_q && (fmt == FMT_BRANCH);
  assign ctrl_o     = (run_q && (fmt == FMT_CTRL)) ? cur_word[CW-1:0] : '0;
endmodule

// File: rtl/usq_sequencer_chk.sv
module usq_sequencer_chk #(
  parameter int unsigned AW  = 5,
  parameter int unsigned CW  = 8,
  parameter int unsigned OPW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [OPW-1:0] opcode_i,
  input logic [CW-1:0]  ctrl_o,
  input logic           br_cycle_o,
  input logic [AW-1:0]  upc_o,
  input logic           run_q,
  input logic           disp_bit,
  input logic [AW-1:0]  br_tgt
);
  localparam int unsigned SHIFT = AW - 1 - OPW;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> (!run_q && upc_o == '0 && ctrl_o == '0 && !br_cycle_o));

  // R2
  start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && start_i) |=> (run_q && upc_o == '0));

  // R2
  keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  // R6
  branch_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_cycle_o |-> (ctrl_o == '0));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !br_cycle_o && !disp_bit) |=> (upc_o == AW'($past(upc_o) + 1'b1)));

  // R5
  dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !br_cycle_o && disp_bit) |=>
      (upc_o == (AW'(1 << (AW - 1)) | (AW'($past(opcode_i)) << SHIFT))));

  // R8
  branch_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_cycle_o |=> (upc_o == AW'($past(upc_o) + 1'b1) || upc_o == $past(br_tgt)));
endmodule

bind usq_sequencer usq_sequencer_chk #(.AW(AW), .CW(CW), .OPW(OPW)) u_chk (.*);

// File: tb/test_usq_sequencer.sv
module test_usq_sequencer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] opcode_i;
  logic [2:0] flags_i;
  logic [7:0] ctrl_o;
  logic       br_cycle_o;
  logic [4:0] upc_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  bit    m_run;
  int    m_pc;
  string m_tag;

  always #5 clk = ~clk;

  usq_sequencer i_usq_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .flags_i(flags_i), .ctrl_o(ctrl_o), .br_cycle_o(br_cycle_o), .upc_o(upc_o)
  );

  // Expected program contents, per R9
  task automatic spec_word(input int a, output bit br, output bit disp, output int ctl,
                           output int sel, output bit inv, output int tgt);
    int k, j;
    br = 0; disp = 0; ctl = 0; sel = 0; inv = 0; tgt = 0;
    if (a < 4) begin
      ctl = a + 1; disp = (a == 3);
    end else if (a < 16) begin
      br = 1;
    end else begin
      k = (a - 16) / 4; j = (a - 16) % 4;
      case (j)
        0: begin br = 1; sel = k; tgt = a + 2; end
        1: ctl = 32 | k;
        2: ctl = 64 | k;
        default: begin br = 1; sel = k; inv = 1; tgt = 0; end
      endcase
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    bit br, disp, inv; int ctl, sel, tgt;
    if (!m_run) begin
      check(upc_o == 0, "R1 upc", upc_o, 0);
      check(ctrl_o == 0, "R1 ctrl", ctrl_o, 0);
      check(br_cycle_o == 0, "R1 br", br_cycle_o, 0);
    end else begin
      spec_word(m_pc, br, disp, ctl, sel, inv, tgt);
      check(upc_o == m_pc, m_tag, upc_o, m_pc);
      if (br) begin
        check(ctrl_o == 0, "R6 ctrl", ctrl_o, 0);
        check(br_cycle_o == 1, "R6 br", br_cycle_o, 1);
      end else begin
        check(ctrl_o == ctl, "R3 ctrl", ctrl_o, ctl);
        check(br_cycle_o == 0, "R3 br", br_cycle_o, 0);
      end
    end
  endtask

  task automatic model_step();
    bit br, disp, inv, c; int ctl, sel, tgt;
    if (!m_run) begin
      if (start_i) begin m_run = 1; m_pc = 0; m_tag = "R2 start"; end
      return;
    end
    spec_word(m_pc, br, disp, ctl, sel, inv, tgt);
    if (br) begin
      c = ((sel == 0) ? 1'b1 : flags_i[sel-1]) ^ inv;
      if (c) begin m_pc = tgt; m_tag = "R7 taken"; end
      else begin m_pc = (m_pc + 1) % 32; m_tag = "R8 fallthrough"; end
    end else if (disp) begin
      m_pc = 16 + 4 * opcode_i; m_tag = "R5 dispatch";
    end else begin
      m_pc = (m_pc + 1) % 32; m_tag = "R4 sequential";
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; opcode_i = '0; flags_i = '0;
    for (int op = 0; op < 4; op++) begin
      for (int fl = 0; fl < 8; fl++) begin
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0;
        opcode_i = 2'(op); flags_i = 3'(fl);
        m_run = 0; m_pc = 0; m_tag = "R1";
        @(negedge clk);
        compare_outputs();  // R1 during reset
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 28; cyc++) begin
          @(negedge clk);
          compare_outputs();
          // R2: start at cycle 2; extra pulses while running must be ignored
          start_i = (cyc == 2) || (cyc == 9) || (cyc == 15 && fl[0]);
          model_step();
        end
      end
    end
    finish_run();
  end
endmodule